// File: doc/BRIEF.md
# Four-Lane Link Test Pattern Generator

This block sources a known data stream for exercising a multi-lane serial link. Each of four 16-bit lanes carries its own fixed pattern on every user clock. Two lanes hold alternating-bit constants. One lane counts up and one counts down, so the far end can spot any lost, repeated or reordered sample. A receiver-side checker or an oscilloscope on a converter output can then compare the received stream against the expected sequence.

The link stops carrying user data for a short resynchronisation window at a fixed interval. The generator keeps its own interval counter. During each window it lowers its valid flag, raises a resync indicator and freezes both ramps, so the ramp sequence carries on across the gap without a skipped or repeated value. A one-cycle start marker comes with the first valid sample after reset. It gives a reference edge for measuring the latency from transmit to receive. Serialisation, transceivers, lane bonding and the physical link lie outside this block.

Top module: `lane_pattern_gen`

## Requirements
- R1: Lane 0 always presents 0xAAAA and lane 2 always presents 0xCCCC, including while reset is held.
- R2: While the synchronous active-high reset is sampled high, valid, resync and start are low, lane 1 reads 0x0000 and lane 3 reads 0xFFFF.
- R3: Lane 1 presents 0x0000 with the first valid sample after reset, and rises by one on each later valid sample.
- R4: Lane 3 presents 0xFFFF with the first valid sample after reset, and falls by one on each later valid sample.
- R5: Both ramps wrap modulo 2^16: 0xFFFF is followed by 0x0000 on lane 1, and 0x0000 is followed by 0xFFFF on lane 3.
- R6: Number the clock edges after reset release from 0. The resync indicator is high after edge k exactly when (k mod 4992) is 4986 or more, which gives one window of 6 consecutive cycles in every 4992 clocks.
- R7: Outside reset, valid is the exact complement of resync.
- R8: During a resync window, lanes 1 and 3 hold their last values. The first valid sample after the window continues each ramp by exactly one step.
- R9: Start is high for exactly one cycle, together with the first valid sample after reset, and stays low after that until the next reset.
- R10: A reset applied mid-run restarts the interval counter, the ramps and the start marker, so R2, R3, R4, R6 and R9 hold again counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| lane0_o | output | 16 | Constant lane, 0xAAAA |
| lane1_o | output | 16 | Incrementing ramp lane |
| lane2_o | output | 16 | Constant lane, 0xCCCC |
| lane3_o | output | 16 | Decrementing ramp lane |
| valid_o | output | 1 | Lanes hold a new sample this cycle |
| resync_o | output | 1 | Link resynchronisation window in progress |
| start_o | output | 1 | One-cycle marker on the first valid sample after reset |

## Verification
Every output except the constant lanes is registered once. A sample or flag for edge k therefore appears straight after that edge. The one exception is the first edge after reset release, which already produces sample 0 and the start marker. The bench's reference model steps on each rising edge and works out the expected value from the edge index since release. The outputs are compared on the following falling edge, so each comparison sees the value from exactly one register stage. The run is long enough for the ramps to wrap. A reset in mid-run is timed to land outside a window, and the bench checks that the window timing restarts from the new release.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int LPG_LANE_W  = 16;
    localparam int LPG_PERIOD  = 4992;
    localparam int LPG_WIN_LEN = 6;

    localparam logic [LPG_LANE_W-1:0] LPG_FILL_A = 16'hAAAA;
    localparam logic [LPG_LANE_W-1:0] LPG_FILL_B = 16'hCCCC;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic valid;
        logic resync;
        logic start;
    } lpg_flags_t;

    // Seed bit replicated over the lane: all ones for a falling ramp.
    function automatic logic ramp_seed_bit(ramp_dir_e dir);
        return (dir == RAMP_DOWN);
    endfunction

endpackage

// File: rtl/lpg_window_timer.sv
module lpg_window_timer #(
    parameter int PERIOD  = lpg_pkg::LPG_PERIOD,
    parameter int WIN_LEN = lpg_pkg::LPG_WIN_LEN
) (
    input  logic clk,
    input  logic rst,
    output logic slot_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST      = CW'(PERIOD - 1);
    localparam logic [CW-1:0] WIN_START = CW'(PERIOD - WIN_LEN);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // A data slot is any phase before the closing window.
    assign slot_o = (phase_q < WIN_START);

endmodule

// File: rtl/lpg_ramp.sv
module lpg_ramp #(
    parameter int                W   = lpg_pkg::LPG_LANE_W,
    parameter lpg_pkg::ramp_dir_e DIR = lpg_pkg::RAMP_UP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    output logic [W-1:0] lane_o
);
    localparam logic [W-1:0] SEED = {W{lpg_pkg::ramp_seed_bit(DIR)}};

    logic [W-1:0] next_q;
    logic [W-1:0] step;

    generate
        if (DIR == lpg_pkg::RAMP_UP) begin : g_up
            assign step = next_q + 1'b1;
        end else begin : g_down
            assign step = next_q - 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= SEED;
            lane_o <= SEED;
        end else if (adv_i) begin
            lane_o <= next_q;
            next_q <= step;
        end
    end

endmodule

// File: rtl/lpg_start_marker.sv
module lpg_start_marker (
    input  logic clk,
    input  logic rst,
    input  logic slot_i,
    output logic start_o
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            start_o <= slot_i & ~seen_q;
            seen_q  <= seen_q | slot_i;
        end
    end

endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
    parameter int                 LANE_W  = lpg_pkg::LPG_LANE_W,
    parameter int                 PERIOD  = lpg_pkg::LPG_PERIOD,
    parameter int                 WIN_LEN = lpg_pkg::LPG_WIN_LEN,
    parameter logic [LANE_W-1:0]  FILL_A  = lpg_pkg::LPG_FILL_A,
    parameter logic [LANE_W-1:0]  FILL_B  = lpg_pkg::LPG_FILL_B
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LANE_W-1:0] lane0_o,
    output logic [LANE_W-1:0] lane1_o,
    output logic [LANE_W-1:0] lane2_o,
    output logic [LANE_W-1:0] lane3_o,
    output logic              valid_o,
    output logic              resync_o,
    output logic              start_o
);
    localparam int NRAMP = 2;

    lpg_pkg::lpg_flags_t flags_q;
    logic                slot;
    logic                start_w;
    logic [LANE_W-1:0]   ramp_lane [NRAMP];

    lpg_window_timer #(.PERIOD(PERIOD), .WIN_LEN(WIN_LEN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .slot_o (slot)
    );

    for (genvar g = 0; g < NRAMP; g++) begin : g_ramp
        lpg_ramp #(.W(LANE_W), .DIR(lpg_pkg::ramp_dir_e'(g))) u_ramp (
            .clk    (clk),
            .rst    (rst),
            .adv_i  (slot),
            .lane_o (ramp_lane[g])
        );
    end

    lpg_start_marker u_start (
        .clk     (clk),
        .rst     (rst),
        .slot_i  (slot),
        .start_o (start_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q.valid  <= 1'b0;
            flags_q.resync <= 1'b0;
        end else begin
            flags_q.valid  <= slot;
            flags_q.resync <= ~slot;
        end
    end

    always_comb flags_q.start = start_w;

    assign lane0_o  = FILL_A;
    assign lane2_o  = FILL_B;
    assign lane1_o  = ramp_lane[0];
    assign lane3_o  = ramp_lane[1];
    assign valid_o  = flags_q.valid;
    assign resync_o = flags_q.resync;
    assign start_o  = flags_q.start;

endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
    parameter int                W      = 16,
    parameter int                LEN    = 6,
    parameter logic [W-1:0]      FILL_A = 16'hAAAA,
    parameter logic [W-1:0]      FILL_B = 16'hCCCC
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] lane0_o,
    input logic [W-1:0] lane1_o,
    input logic [W-1:0] lane2_o,
    input logic [W-1:0] lane3_o,
    input logic         valid_o,
    input logic         resync_o,
    input logic         start_o
);
    localparam int RW = $clog2(LEN + 2);

    logic [RW-1:0] run_q;
    logic          was_rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            was_rst_q <= 1'b1;
        end else begin
            run_q     <= resync_o ? run_q + 1'b1 : '0;
            was_rst_q <= 1'b0;
        end
    end

    // R1
    fill_lanes_chk: assert property (@(posedge clk)
        lane0_o == FILL_A && lane2_o == FILL_B);

    // R7
    valid_vs_resync_chk: assert property (@(posedge clk) disable iff (rst)
        !was_rst_q |-> (valid_o != resync_o));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!was_rst_q && valid_o && $past(valid_o)) |-> lane1_o == W'($past(lane1_o) + 1'b1));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!was_rst_q && valid_o && $past(valid_o)) |-> lane3_o == W'($past(lane3_o) - 1'b1));

    // R8
    hold_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!was_rst_q && resync_o) |-> ($stable(lane1_o) && $stable(lane3_o)));

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!was_rst_q && $fell(resync_o)) |-> run_q == RW'(LEN));

    // R9
    start_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> valid_o);

    // R9
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

bind lane_pattern_gen lpg_checker #(
    .W(LANE_W), .LEN(WIN_LEN), .FILL_A(FILL_A), .FILL_B(FILL_B)
) u_lpg_checker (
    .clk(clk), .rst(rst),
    .lane0_o(lane0_o), .lane1_o(lane1_o), .lane2_o(lane2_o), .lane3_o(lane3_o),
    .valid_o(valid_o), .resync_o(resync_o), .start_o(start_o)
);

// File: tb/lane_pattern_gen_bench.sv
module lane_pattern_gen_bench;
    localparam int P = 4992;
    localparam int L = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lane0, lane1, lane2, lane3;
    logic        valid, resync, start;

    always #10 clk = ~clk;

    lane_pattern_gen u_lane_pattern_gen (
        .clk(clk), .rst(rst),
        .lane0_o(lane0), .lane1_o(lane1), .lane2_o(lane2), .lane3_o(lane3),
        .valid_o(valid), .resync_o(resync), .start_o(start)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Behavioural reference: edge index since release and ramp counters.
    int edge_idx, up_next, dn_next;
    bit started, ready, rst_seen, mid;
    int x_valid, x_res, x_start, x_up, x_dn;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        ready    = 1'b1;
        rst_seen = rst;
        if (rst) begin
            edge_idx = 0; up_next = 0; dn_next = 'hFFFF; started = 1'b0;
            x_valid = 0; x_res = 0; x_start = 0; x_up = 0; x_dn = 'hFFFF;
        end else begin
            if ((edge_idx % P) < P - L) begin
                x_valid = 1; x_res = 0;
                x_up = up_next; x_dn = dn_next;
                up_next = (up_next + 1) % 65536;
                dn_next = (dn_next + 65535) % 65536;
                x_start = started ? 0 : 1;
                started = 1'b1;
            end else begin
                x_valid = 0; x_res = 1; x_start = 0;
            end
            edge_idx++;
        end
    end

    always @(negedge clk) begin
        if (ready && !done) begin
            chk("R1 lane0", lane0, 32'hAAAA);
            chk("R1 lane2", lane2, 32'hCCCC);
            if (rst_seen) begin
                chk("R2 valid", valid, 0);
                chk("R2 resync", resync, 0);
                chk("R2 start", start, 0);
                chk("R2 lane1", lane1, 0);
                chk("R2 lane3", lane3, 32'hFFFF);
            end else begin
                chk(x_res ? "R8 lane1" : (x_up == 0 ? "R5 lane1" : "R3 lane1"), lane1, x_up);
                chk(x_res ? "R8 lane3" : (x_dn == 'hFFFF ? "R5 lane3" : "R4 lane3"), lane3, x_dn);
                chk((mid && edge_idx <= P) ? "R10 resync" : "R6 resync", resync, x_res);
                chk("R7 valid", valid, x_valid);
                chk((mid && edge_idx <= 2) ? "R10 start" : "R9 start", start, x_start);
            end
        end
    end

    initial begin
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // Long enough for both ramps to wrap (R5).
        repeat (70000) @(negedge clk);
        // Mid-run reset outside a window (R10).
        rst = 1'b1;
        mid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (12000) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule